// File: doc/BRIEF.md
# Pipelined Burst Synchronous Static Memory

This block is a synchronous static memory with a built-in burst address generator. Every control input is sampled on the rising clock edge. Each edge is decoded as one of four cycle types: a deselect, a burst start at the external address, a burst continue at the next address, or a burst suspend that repeats the current address. Two address strobes open bursts under different rules. One belongs to the processor and always opens a read. The other belongs to a memory controller and opens a read or a write according to the write-enable decode.

Writes are byte-masked. A global write enable overrides the per-byte path. Read data comes back through one output register. The tristate data pins are modelled as a data bus plus an output-valid flag. Output enable and a sleep input can force that flag low without a clock. The default depth is 256 words so that the whole array can be swept. Setting `ADDR_W` to 15 gives a 32K-word part.

Top module: `sram_burst_core`

## Requirements
- R1: The chip is selected only when `sel_n_a`=0, `sel_b`=1 and `sel_n_c`=0. A cycle that opens with a strobe under any other select combination is a deselect: it writes nothing, produces no read data, and ends any active burst.
- R2: While `sel_n_a`=1, a low `cpu_strb_n` is ignored, and the cycle behaves as a continue or a suspend. A low `ctl_strb_n` in that state causes a deselect.
- R3: When selected, `cpu_strb_n`=0 starts a burst read at `addr`, whatever the write enables say.
- R4: When selected, `cpu_strb_n`=1 and `ctl_strb_n`=0 start a burst at `addr`. The burst is a write when the write decode asks for one, and a read otherwise.
- R5: When both strobes are inactive and a burst is active, `adv_n`=0 moves to the next address. The low two address bits count up modulo 4, and the upper bits are held from the start address.
- R6: When both strobes are inactive and a burst is active, `adv_n`=1 repeats the current address.
- R7: `gwr_n`=0 writes all four bytes, whatever `bwr_n` and `be_n` are.
- R8: When `gwr_n`=1 and `bwr_n`=0, byte i (data bits 8i+7..8i) is written only where `be_n[i]`=0. When `be_n`=4'hF, memory is left unchanged.
- R9: The read data for a cycle sampled at edge N is on `rdata`, with `rvalid`=1, after edge N+1.
- R10: `rvalid` is 1 only while `oe_n`=0 and `sleep`=0, both applied without a clock. While `rvalid`=0, `rdata` is all zeros.
- R11: Write cycles and deselect cycles never raise `rvalid`.
- R12: In continue and suspend cycles, the read or write type comes from that cycle's write decode. With no active burst and no strobe, no access takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of burst and output state |
| sel_n_a | input | 1 | Chip select, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_n_c | input | 1 | Chip select, active low |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, low = next address, high = suspend |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte write enable, active low |
| be_n | input | 4 | Per-byte enables, active low |
| addr | input | ADDR_W | External word address |
| wdata | input | 32 | Write data |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Sleep, forces outputs off |
| rdata | output | 32 | Read data, zero when not valid |
| rvalid | output | 1 | Models the data pins being driven |

## Verification
The array is filled through controller-strobed four-word write bursts. It is then read back with a processor-strobed burst starting at every address, so that wrap-around within each 4-word group is seen from each of the four offsets. Each of the 16 byte-enable patterns is written to a fresh word and read back; this separates global from per-byte writes and confirms that the empty mask leaves the word alone. All eight select combinations are applied under a write strobe, and the processor and controller strobes are applied with the first select high; together these separate a deselect from an ignored strobe. Suspend sequences, write-in-continue cycles and toggling of `oe_n` and `sleep` cover the remaining decode and output-gating cases.

// File: rtl/sram_burst_core.sv
`timescale 1ns/1ps
module sram_burst_core #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_a,
  input  logic              sel_b,
  input  logic              sel_n_c,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              adv_n,
  input  logic              gwr_n,
  input  logic              bwr_n,
  input  logic [DATA_W/8-1:0] be_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int NB    = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              act_q, rd_q, vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dout_q;

  wire cpu_go  = !sel_n_a && !cpu_strb_n;
  wire new_cyc = cpu_go || !ctl_strb_n;
  wire chip_on = !sel_n_a && sel_b && !sel_n_c;
  wire wr_req  = !gwr_n || !bwr_n;

  wire [NB-1:0] bmask = !gwr_n ? {NB{1'b1}} : (!bwr_n ? ~be_n : {NB{1'b0}});

  logic [BURST_W-1:0] low_nxt;
  logic [ADDR_W-1:0]  step_addr;
  assign low_nxt   = addr_q[BURST_W-1:0] + 1'b1;
  assign step_addr = {addr_q[ADDR_W-1:BURST_W], low_nxt};

  logic              acc, acc_wr;
  logic [ADDR_W-1:0] eaddr;

  always_comb begin
    acc    = 1'b0;
    acc_wr = 1'b0;
    eaddr  = addr_q;
    if (new_cyc) begin
      if (chip_on) begin
        acc    = 1'b1;
        eaddr  = addr;
        acc_wr = cpu_go ? 1'b0 : wr_req;
      end
    end else if (act_q) begin
      acc    = 1'b1;
      acc_wr = wr_req;
      eaddr  = adv_n ? addr_q : step_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      vld_q  <= 1'b0;
      addr_q <= '0;
      dout_q <= '0;
    end else begin
      if (new_cyc) act_q <= chip_on;
      if (acc) addr_q <= eaddr;
      rd_q  <= acc && !acc_wr;
      vld_q <= rd_q;
      if (rd_q) dout_q <= mem[addr_q];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++)
      if (acc && acc_wr && bmask[i])
        mem[eaddr][i*8 +: 8] <= wdata[i*8 +: 8];
  end

  assign rvalid = vld_q && !oe_n && !sleep;
  assign rdata  = rvalid ? dout_q : '0;
endmodule

// File: rtl/sram_burst_chk.sv
`timescale 1ns/1ps
module sram_burst_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n_a,
  input logic              sel_b,
  input logic              sel_n_c,
  input logic              cpu_strb_n,
  input logic              ctl_strb_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rvalid,
  input logic              act_q,
  input logic [ADDR_W-1:0] addr_q
);
  wire go  = !sel_n_a && !cpu_strb_n;
  wire nc  = go || !ctl_strb_n;
  wire on  = !sel_n_a && sel_b && !sel_n_c;

  // R1
  deselect_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nc && !on) |=> !act_q);

  // R11
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nc && !on) |=> ##1 !rvalid);

  // R3
  cpu_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && on) |=> (addr_q == $past(addr)));

  // R6
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nc && act_q && adv_n) |=> $stable(addr_q));

  // R5
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nc && act_q && !adv_n) |=>
      (addr_q[ADDR_W-1:BURST_W] == $past(addr_q[ADDR_W-1:BURST_W])) &&
      (addr_q[BURST_W-1:0] == $past(addr_q[BURST_W-1:0]) + 1'b1));

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rvalid);
endmodule

bind sram_burst_core sram_burst_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_W(BURST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n_a(sel_n_a), .sel_b(sel_b), .sel_n_c(sel_n_c),
  .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .adv_n(adv_n), .oe_n(oe_n),
  .addr(addr), .rvalid(rvalid), .act_q(act_q), .addr_q(addr_q)
);

// File: tb/sram_burst_core_bench.sv
`timescale 1ns/1ps
module sram_burst_core_bench;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic s_na, s_b, s_nc, cpu_n, ctl_n, adv, gw_n, bw_n, oe_n, slp;
  logic [3:0]    be_n;
  logic [AW-1:0] ad;
  logic [DW-1:0] wd;
  logic [DW-1:0] rdata;
  logic          rvalid;

  sram_burst_core #(.ADDR_W(AW), .DATA_W(DW), .BURST_W(2)) u_sram_burst_core (
    .clk(clk), .rst_n(rst_n), .sel_n_a(s_na), .sel_b(s_b), .sel_n_c(s_nc),
    .cpu_strb_n(cpu_n), .ctl_strb_n(ctl_n), .adv_n(adv), .gwr_n(gw_n),
    .bwr_n(bw_n), .be_n(be_n), .addr(ad), .wdata(wd), .oe_n(oe_n),
    .sleep(slp), .rdata(rdata), .rvalid(rvalid)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [DW-1:0] model [1<<AW];
  logic          m_act;
  logic [AW-1:0] m_addr;
  logic          prev_rd;
  logic [DW-1:0] prev_d;
  string         prev_tag;

  function automatic logic [DW-1:0] dat(input int a, input int k);
    return (32'(a) * 32'h9E3779B1) ^ (32'(k) << 24);
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic go, nc, on, wr, acc, accw;
    logic [AW-1:0] ea;
    logic [3:0] bm;
    logic cur_rd;
    logic [DW-1:0] cur_d;
    logic [DW-1:0] tmp;
    logic ev;
    go = !s_na && !cpu_n;
    nc = go || !ctl_n;
    on = !s_na && s_b && !s_nc;
    wr = !gw_n || !bw_n;
    bm = !gw_n ? 4'hF : (!bw_n ? ~be_n : 4'h0);
    acc = 0; accw = 0; ea = m_addr;
    if (nc) begin
      if (on) begin acc = 1; ea = ad; accw = go ? 1'b0 : wr; end
    end else if (m_act) begin
      acc = 1; accw = wr;
      ea = adv ? m_addr : {m_addr[AW-1:2], 2'(m_addr[1:0] + 2'd1)};
    end
    cur_rd = acc && !accw;
    cur_d  = model[ea];
    if (acc && accw) begin
      tmp = model[ea];
      for (int i = 0; i < 4; i++)
        if (bm[i]) tmp[i*8 +: 8] = wd[i*8 +: 8];
      model[ea] = tmp;
    end
    if (nc) m_act = on;
    if (acc) m_addr = ea;
    @(posedge clk); #1;
    ev = prev_rd && !oe_n && !slp;
    check({31'd0, rvalid}, {31'd0, ev}, {"R9 R10 R11 rvalid after ", prev_tag});
    check(rdata, ev ? prev_d : '0, {"R9 R10 rdata after ", prev_tag});
    prev_rd = cur_rd; prev_d = cur_d; prev_tag = tag;
  endtask

  task automatic cmd(input logic c, input logic k, input logic a_n, input logic g,
                     input logic b, input logic [3:0] e, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input string tag);
    cpu_n = c; ctl_n = k; adv = a_n; gw_n = g; bw_n = b; be_n = e; ad = a; wd = d;
    step(tag);
  endtask

  task automatic sel_ok;
    s_na = 0; s_b = 1; s_nc = 0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; sel_ok(); cpu_n = 1; ctl_n = 1; adv = 1; gw_n = 1; bw_n = 1;
    be_n = 4'hF; ad = '0; wd = '0; oe_n = 0; slp = 0;
    m_act = 0; m_addr = '0; prev_rd = 0; prev_d = '0; prev_tag = "reset";
    for (int i = 0; i < (1<<AW); i++) model[i] = 'x;
    repeat (4) @(posedge clk);
    #1;
    check({31'd0, rvalid}, 32'd0, "R10 reset rvalid");
    check(rdata, '0, "R10 reset rdata");
    rst_n = 1;
    @(posedge clk); #1;

    // R4 R7 R5: fill through controller write bursts
    for (int a = 0; a < (1<<AW); a += 4) begin
      cmd(1, 0, 1, 0, 1, 4'hF, AW'(a), dat(a, 1), "R4 R7 write start");
      for (int k = 1; k < 4; k++)
        cmd(1, 1, 0, 0, 1, 4'hF, '0, dat(a + k, 1), "R5 R12 write continue");
    end

    // R3 R5: processor read burst from every start, write enables asserted
    for (int s = 0; s < (1<<AW); s++) begin
      cmd(0, 1, 1, 0, 0, 4'h0, AW'(s), 32'hDEAD_BEEF, "R3 read start");
      for (int k = 1; k < 4; k++)
        cmd(1, 1, 0, 1, 1, 4'hF, '0, '0, "R5 read wrap");
    end

    // R6: suspend
    cmd(0, 1, 1, 1, 1, 4'hF, 8'h21, '0, "R3 read start");
    cmd(1, 1, 1, 1, 1, 4'hF, '0, '0, "R6 suspend");
    cmd(1, 1, 1, 1, 1, 4'hF, '0, '0, "R6 suspend");
    cmd(1, 1, 0, 1, 1, 4'hF, '0, '0, "R5 advance after suspend");

    // R8: every byte-enable pattern
    for (int m = 0; m < 16; m++) begin
      cmd(1, 0, 1, 1, 0, 4'(m), AW'(8'h80 + m), 32'hC3C3_C3C3 ^ 32'(m), "R8 byte write");
      cmd(1, 0, 1, 1, 1, 4'hF, AW'(8'h80 + m), '0, "R4 R8 readback");
    end

    // R1: all select combinations under a write strobe
    for (int c = 0; c < 8; c++) begin
      s_na = c[0]; s_b = c[1]; s_nc = c[2];
      cmd(1, 0, 1, 0, 1, 4'hF, AW'(8'hC0 + c), 32'h5A5A_0000 | 32'(c), "R1 select combo");
      sel_ok();
      cmd(0, 1, 1, 1, 1, 4'hF, AW'(8'hC0 + c), '0, "R1 readback");
    end

    // R2: processor strobe ignored with first select high
    cmd(0, 1, 1, 1, 1, 4'hF, 8'h40, '0, "R3 read start");
    s_na = 1;
    cmd(0, 1, 0, 1, 1, 4'hF, 8'h99, '0, "R2 ignored strobe continue");
    cmd(0, 1, 1, 1, 1, 4'hF, 8'h99, '0, "R2 ignored strobe suspend");
    cmd(1, 0, 1, 1, 1, 4'hF, 8'h99, '0, "R2 R1 controller deselect");
    sel_ok();
    cmd(1, 1, 0, 0, 1, 4'hF, 8'h41, 32'hBAD0_BAD0, "R12 idle no access");
    cmd(1, 1, 0, 1, 1, 4'hF, 8'h41, '0, "R12 idle no access");
    cmd(0, 1, 1, 1, 1, 4'hF, 8'h41, '0, "R12 readback");
    cmd(1, 1, 0, 1, 1, 4'hF, '0, '0, "R12 readback");

    // R10: output enable and sleep gating
    cmd(0, 1, 1, 1, 1, 4'hF, 8'h10, '0, "R3 read start");
    oe_n = 1;
    cmd(1, 1, 0, 1, 1, 4'hF, '0, '0, "R10 oe off");
    oe_n = 0;
    cmd(1, 1, 0, 1, 1, 4'hF, '0, '0, "R10 oe on");
    slp = 1;
    cmd(1, 1, 0, 1, 1, 4'hF, '0, '0, "R10 sleep");
    slp = 0;
    cmd(1, 1, 0, 1, 1, 4'hF, '0, '0, "R10 awake");

    // R12: write within a read-started burst, R11 write gives no data
    cmd(0, 1, 1, 1, 1, 4'hF, 8'h50, '0, "R3 read start");
    cmd(1, 1, 0, 0, 1, 4'hF, '0, 32'h1234_5678, "R12 R11 continue write");
    cmd(1, 1, 1, 1, 0, 4'hA, '0, 32'hFFFF_FFFF, "R12 R8 suspend byte write");
    cmd(1, 1, 1, 1, 1, 4'hF, '0, '0, "R12 suspend read");
    cmd(0, 1, 1, 1, 1, 4'hF, 8'h50, '0, "R3 readback");
    for (int k = 0; k < 4; k++)
      cmd(1, 1, 0, 1, 1, 4'hF, '0, '0, "R5 readback");
    s_b = 0;
    cmd(1, 0, 1, 1, 1, 4'hF, '0, '0, "R1 final deselect");
    sel_ok();
    cmd(1, 1, 1, 1, 1, 4'hF, '0, '0, "R11 idle");
    cmd(1, 1, 1, 1, 1, 4'hF, '0, '0, "R11 idle");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule